// File: doc/BRIEF.md
# Guest Translation Cache with Scoped Fence

This block is a small, fully associative cache of guest-stage address translations for one hart. Each slot holds a virtual machine identifier, an address-space identifier, a guest virtual page number, a physical page number and a global flag. A fill port writes new translations into slots in round-robin order. A combinational lookup port returns a hit flag and the physical page number.

A fence command port removes stale translations from the cache. The command carries an optional guest page (the address operand is either supplied or x0) and an optional guest address-space identifier (supplied or x0). It also carries the privilege state of the issuing hart, and the machine identifier held in the hypervisor translation register. Only slots owned by that machine identifier are candidates for removal. The ASID operand never selects the machine.

A fence from an unprivileged or virtualized mode changes nothing and raises an illegal-instruction pulse. The two trap-on-virtual-memory control bits take no part in that decision. A fence acts only on this local cache.

Top module: `gtlb_fence_top`

## Requirements
- R1: After reset every slot is empty, every lookup misses, and `fence_done_o` and `fence_illegal_o` are low.
- R2: A lookup hits when a slot is valid, its VMID and page number equal the lookup's, and either its ASID equals the lookup ASID or its global flag is set; `lk_ppn_o` then carries that slot's physical page.
- R3: A legal fence raises `fence_done_o` for exactly one cycle, in the cycle after the command, with `fence_illegal_o` low.
- R4: A legal fence with both operands absent (`fence_addr_valid_i`=0, `fence_asid_valid_i`=0) removes every slot of the current VMID, global slots included.
- R5: When `fence_addr_valid_i`=1, only slots whose page number equals `fence_vpn_i` are removed.
- R6: When `fence_asid_valid_i`=1, only non-global slots whose ASID equals `fence_asid_i` are removed; global slots survive.
- R7: Removal is limited to slots whose VMID equals `hgatp_vmid_i`; slots of other VMIDs survive every fence, even when the ASID operand equals their VMID value.
- R8: Legality is decided from `fence_priv_i` (2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 reserved) and `fence_virt_i`. Only machine mode, or supervisor mode with `fence_virt_i`=0, is legal. Any other fence raises `fence_illegal_o` for one cycle, in the cycle after the command, leaves `fence_done_o` low, and removes no slot.
- R9: `tvm_i` and `vtvm_i` have no effect on a fence's legality or its result.
- R10: A lookup in the same cycle as a fence sees the contents from before the fence. A lookup in any later cycle sees the contents after the fence.
- R11: Fills go to slots 0,1,...,N_ENT-1 and then wrap to 0, so the ninth fill replaces the first one. A fill in the same cycle as a fence is written after the removal, and its slot survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Write a translation into the next slot |
| fill_vmid_i | input | VMID_W | VMID of the new translation |
| fill_asid_i | input | ASID_W | ASID of the new translation |
| fill_vpn_i | input | VPN_W | Guest virtual page of the new translation |
| fill_ppn_i | input | PPN_W | Physical page of the new translation |
| fill_global_i | input | 1 | The new translation is global |
| lk_vmid_i | input | VMID_W | Lookup VMID |
| lk_asid_i | input | ASID_W | Lookup ASID |
| lk_vpn_i | input | VPN_W | Lookup guest virtual page |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PPN_W | Physical page of the hit, zero on a miss |
| fence_valid_i | input | 1 | Fence command strobe |
| fence_addr_valid_i | input | 1 | Address operand supplied (0 means x0) |
| fence_vpn_i | input | VPN_W | Guest page from the address operand |
| fence_asid_valid_i | input | 1 | ASID operand supplied (0 means x0) |
| fence_asid_i | input | ASID_W | Guest ASID operand |
| fence_priv_i | input | 2 | Privilege of the issuing hart |
| fence_virt_i | input | 1 | Hart is in a virtualized mode |
| hgatp_vmid_i | input | VMID_W | Current VMID from the hypervisor translation register |
| tvm_i | input | 1 | Trap-virtual-memory bit (ignored) |
| vtvm_i | input | 1 | Virtual trap-virtual-memory bit (ignored) |
| fence_done_o | output | 1 | Legal fence completed |
| fence_illegal_o | output | 1 | Illegal-instruction pulse |

## Verification
The assertions assume a fence strobe lasts one cycle and that two fence commands are never issued in back-to-back cycles. Under that assumption each done or illegal pulse can be tied to the single command one cycle earlier. They also assume no other logic writes the slots, so a slot can only be cleared in a cycle that carries a fence. The stimulus always puts at least one lookup cycle between fences and drives the fence strobe only through a task that holds it for one clock. The one case that mixes a fill and a fence in the same cycle is handled by the fill-landing property and not by the no-removal property.

// File: rtl/gtlb_pkg.sv
package gtlb_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/gtlb_rr.sv
module gtlb_rr #(
  parameter int N_ENT = 8,
  localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == PTR_W'(N_ENT - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/gtlb_entry.sv
module gtlb_entry #(
  parameter int VMID_W = 7,
  parameter int ASID_W = 9,
  parameter int VPN_W  = 27,
  parameter int PPN_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [VMID_W-1:0] wr_vmid_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              wr_glb_i,
  input  logic              kill_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [VMID_W-1:0] f_vmid_i,
  input  logic              f_addr_v_i,
  input  logic [VPN_W-1:0]  f_vpn_i,
  input  logic              f_asid_v_i,
  input  logic [ASID_W-1:0] f_asid_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              fmatch_o
);
  logic [VMID_W-1:0] vmid_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic              glb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vmid_q  <= '0;
      asid_q  <= '0;
      vpn_q   <= '0;
      ppn_o   <= '0;
      glb_q   <= 1'b0;
    end else if (wr_i) begin
      // fill takes precedence over a same-cycle kill
      valid_o <= 1'b1;
      vmid_q  <= wr_vmid_i;
      asid_q  <= wr_asid_i;
      vpn_q   <= wr_vpn_i;
      ppn_o   <= wr_ppn_i;
      glb_q   <= wr_glb_i;
    end else if (kill_i) begin
      valid_o <= 1'b0;
    end
  end

  assign hit_o = valid_o && (vmid_q == lk_vmid_i) && (vpn_q == lk_vpn_i)
              && (glb_q || (asid_q == lk_asid_i));

  // global entries escape an ASID-scoped fence
  assign fmatch_o = valid_o && (vmid_q == f_vmid_i)
                 && (!f_addr_v_i || (vpn_q == f_vpn_i))
                 && (!f_asid_v_i || (!glb_q && (asid_q == f_asid_i)));
endmodule

// File: rtl/gtlb_fence_top.sv
module gtlb_fence_top
  import gtlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int VMID_W = 7,
  parameter int ASID_W = 9,
  parameter int VPN_W  = 27,
  parameter int PPN_W  = 22,
  localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              fill_global_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_hit_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  input  logic              fence_valid_i,
  input  logic              fence_addr_valid_i,
  input  logic [VPN_W-1:0]  fence_vpn_i,
  input  logic              fence_asid_valid_i,
  input  logic [ASID_W-1:0] fence_asid_i,
  input  logic [1:0]        fence_priv_i,
  input  logic              fence_virt_i,
  input  logic [VMID_W-1:0] hgatp_vmid_i,
  input  logic              tvm_i,
  input  logic              vtvm_i,
  output logic              fence_done_o,
  output logic              fence_illegal_o
);
  logic [PTR_W-1:0] wr_ptr;
  logic [N_ENT-1:0] ent_valid, ent_hit, ent_fm, ent_kill;
  logic [PPN_W-1:0] ent_ppn [N_ENT];
  logic             legal, fence_go;

  // privilege alone decides legality; trap-vm bits deliberately unused here
  always_comb begin
    case (fence_priv_i)
      PRIV_M:  legal = 1'b1;
      PRIV_S:  legal = !fence_virt_i;
      default: legal = 1'b0;
    endcase
  end
  assign fence_go = fence_valid_i && legal;

  gtlb_rr #(.N_ENT(N_ENT)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (fill_valid_i),
    .ptr_o (wr_ptr)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign ent_kill[g] = fence_go && ent_fm[g];
    gtlb_entry #(
      .VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
    ) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (fill_valid_i && (wr_ptr == PTR_W'(g))),
      .wr_vmid_i (fill_vmid_i),
      .wr_asid_i (fill_asid_i),
      .wr_vpn_i  (fill_vpn_i),
      .wr_ppn_i  (fill_ppn_i),
      .wr_glb_i  (fill_global_i),
      .kill_i    (ent_kill[g]),
      .lk_vmid_i (lk_vmid_i),
      .lk_asid_i (lk_asid_i),
      .lk_vpn_i  (lk_vpn_i),
      .f_vmid_i  (hgatp_vmid_i),
      .f_addr_v_i(fence_addr_valid_i),
      .f_vpn_i   (fence_vpn_i),
      .f_asid_v_i(fence_asid_valid_i),
      .f_asid_i  (fence_asid_i),
      .valid_o   (ent_valid[g]),
      .hit_o     (ent_hit[g]),
      .ppn_o     (ent_ppn[g]),
      .fmatch_o  (ent_fm[g])
    );
  end

  always_comb begin
    lk_ppn_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_hit[i]) lk_ppn_o = lk_ppn_o | ent_ppn[i];
    end
  end
  assign lk_hit_o = |ent_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fence_done_o    <= 1'b0;
      fence_illegal_o <= 1'b0;
    end else begin
      fence_done_o    <= fence_go;
      fence_illegal_o <= fence_valid_i && !legal;
    end
  end
endmodule

// File: rtl/gtlb_fence_chk.sv
module gtlb_fence_chk #(
  parameter int N_ENT = 8,
  localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fill_valid_i,
  input logic             fence_valid_i,
  input logic [1:0]       fence_priv_i,
  input logic             fence_virt_i,
  input logic             tvm_i,
  input logic             vtvm_i,
  input logic             fence_done_o,
  input logic             fence_illegal_o,
  input logic [N_ENT-1:0] valid_i,
  input logic [PTR_W-1:0] ptr_i
);
  a_r3_done_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |-> $past(fence_valid_i));

  a_r3_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fence_done_o && fence_illegal_o));

  a_r8_user_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_priv_i == 2'b00) |=> (fence_illegal_o && !fence_done_o));

  a_r8_virt_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_priv_i == 2'b01 && fence_virt_i) |=> fence_illegal_o);

  a_r8_no_removal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_priv_i != 2'b11 && !(fence_priv_i == 2'b01 && !fence_virt_i)
     && !fill_valid_i) |=> (valid_i == $past(valid_i)));

  a_r9_trap_bits_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_priv_i == 2'b11 && (tvm_i || vtvm_i)) |=> fence_done_o);

  a_r7_no_spurious_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fence_valid_i |=> (($past(valid_i) & ~valid_i) == '0));

  a_r11_fill_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> valid_i[$past(ptr_i)]);
endmodule

bind gtlb_fence_top gtlb_fence_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fill_valid_i   (fill_valid_i),
  .fence_valid_i  (fence_valid_i),
  .fence_priv_i   (fence_priv_i),
  .fence_virt_i   (fence_virt_i),
  .tvm_i          (tvm_i),
  .vtvm_i         (vtvm_i),
  .fence_done_o   (fence_done_o),
  .fence_illegal_o(fence_illegal_o),
  .valid_i        (ent_valid),
  .ptr_i          (wr_ptr)
);

// File: tb/gtlb_fence_top_test.sv
module gtlb_fence_top_test;
  localparam int VMID_W = 7, ASID_W = 9, VPN_W = 27, PPN_W = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              fill_valid = 0, fill_glb = 0;
  logic [VMID_W-1:0] fill_vmid = '0, lk_vmid = '0, hg_vmid = '0;
  logic [ASID_W-1:0] fill_asid = '0, lk_asid = '0, f_asid = '0;
  logic [VPN_W-1:0]  fill_vpn = '0, lk_vpn = '0, f_vpn = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic              f_valid = 0, f_av = 0, f_asv = 0, f_virt = 0, tvm = 0, vtvm = 0;
  logic [1:0]        f_priv = 2'b11;
  logic              lk_hit, done, ill;
  logic [PPN_W-1:0]  lk_ppn;

  gtlb_fence_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_vmid_i(fill_vmid), .fill_asid_i(fill_asid),
    .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_global_i(fill_glb),
    .lk_vmid_i(lk_vmid), .lk_asid_i(lk_asid), .lk_vpn_i(lk_vpn),
    .lk_hit_o(lk_hit), .lk_ppn_o(lk_ppn),
    .fence_valid_i(f_valid), .fence_addr_valid_i(f_av), .fence_vpn_i(f_vpn),
    .fence_asid_valid_i(f_asv), .fence_asid_i(f_asid), .fence_priv_i(f_priv),
    .fence_virt_i(f_virt), .hgatp_vmid_i(hg_vmid), .tvm_i(tvm), .vtvm_i(vtvm),
    .fence_done_o(done), .fence_illegal_o(ill)
  );

  typedef struct {
    bit              is_look;
    int              due;
    bit              hit;
    logic [PPN_W-1:0] ppn;
    bit              done;
    bit              ill;
    string           req;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc++;

  task automatic fail_line(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // monitor: compares every item due in the current window, before the next edge
  always @(negedge clk) begin
    #4;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (q[i].is_look) begin
          if (lk_hit !== q[i].hit) fail_line(q[i].req, "hit", int'(lk_hit), int'(q[i].hit));
          else if (q[i].hit && lk_ppn !== q[i].ppn)
            fail_line(q[i].req, "ppn", int'(lk_ppn), int'(q[i].ppn));
        end else if (done !== q[i].done || ill !== q[i].ill) begin
          fail_line(q[i].req, "done/ill", int'({done, ill}), int'({q[i].done, q[i].ill}));
        end
        q.delete(i);
      end
    end
  end

  task automatic clear_all();
    fill_valid = 0; f_valid = 0; f_av = 0; f_asv = 0;
    f_priv = 2'b11; f_virt = 0; tvm = 0; vtvm = 0;
  endtask

  task automatic set_fill(int vm, int as, int vpn, int ppn, bit g);
    fill_valid = 1; fill_vmid = VMID_W'(vm); fill_asid = ASID_W'(as);
    fill_vpn = VPN_W'(vpn); fill_ppn = PPN_W'(ppn); fill_glb = g;
  endtask

  task automatic push_look(int vm, int as, int vpn, bit eh, int ep, string req);
    item_t it;
    lk_vmid = VMID_W'(vm); lk_asid = ASID_W'(as); lk_vpn = VPN_W'(vpn);
    it.is_look = 1; it.due = cyc; it.hit = eh; it.ppn = PPN_W'(ep);
    it.done = 0; it.ill = 0; it.req = req;
    q.push_back(it);
  endtask

  task automatic set_fence(bit av, int vpn, bit asv, int as, logic [1:0] pr, bit vt,
                           int vm, bit t, bit vt2, bit legal, string req);
    item_t it;
    f_valid = 1; f_av = av; f_vpn = VPN_W'(vpn); f_asv = asv; f_asid = ASID_W'(as);
    f_priv = pr; f_virt = vt; hg_vmid = VMID_W'(vm); tvm = t; vtvm = vt2;
    it.is_look = 0; it.due = cyc + 1; it.hit = 0; it.ppn = '0;
    it.done = legal; it.ill = !legal; it.req = req;
    q.push_back(it);
    it.due = cyc + 2; it.done = 0; it.ill = 0;
    q.push_back(it);
  endtask

  task automatic do_fill(int vm, int as, int vpn, int ppn, bit g);
    @(negedge clk); clear_all(); set_fill(vm, as, vpn, ppn, g);
  endtask

  task automatic do_look(int vm, int as, int vpn, bit eh, int ep, string req);
    @(negedge clk); clear_all(); push_look(vm, as, vpn, eh, ep, req);
  endtask

  task automatic do_fence(bit av, int vpn, bit asv, int as, logic [1:0] pr, bit vt,
                          int vm, bit t, bit vt2, bit legal, string req);
    @(negedge clk); clear_all();
    set_fence(av, vpn, asv, as, pr, vt, vm, t, vt2, legal, req);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk); #2;
    checks++;
    if (done !== 0 || ill !== 0) fail_line("R1", "done/ill", int'({done, ill}), 0);
    do_look(5, 1, 'h100, 0, 0, "R1");

    // fill slots 0..7
    do_fill(5, 1, 'h100, 'hA00, 0);
    do_fill(5, 1, 'h101, 'hA01, 0);
    do_fill(5, 2, 'h100, 'hA02, 0);
    do_fill(5, 3, 'h200, 'hA03, 1);
    do_fill(9, 1, 'h100, 'hB04, 0);
    do_fill(9, 5, 'h300, 'hB05, 0);
    do_fill(5, 5, 'h300, 'hA06, 0);
    do_fill(5, 1, 'h400, 'hA07, 0);

    // R2: lookup matching rules
    do_look(5, 1, 'h100, 1, 'hA00, "R2");
    do_look(5, 2, 'h100, 1, 'hA02, "R2");
    do_look(9, 1, 'h100, 1, 'hB04, "R2");
    do_look(5, 2, 'h101, 0, 0, "R2");
    do_look(5, 7, 'h200, 1, 'hA03, "R2");
    do_look(7, 1, 'h100, 0, 0, "R2");

    // R8: user mode and virtualized supervisor are illegal, nothing removed
    do_fence(0, 0, 0, 0, 2'b00, 0, 5, 0, 0, 0, "R8");
    do_look(5, 1, 'h100, 1, 'hA00, "R8");
    do_fence(0, 0, 0, 0, 2'b01, 1, 5, 0, 0, 0, "R8");
    do_look(5, 3, 'h200, 1, 'hA03, "R8");
    do_fence(0, 0, 0, 0, 2'b10, 0, 5, 0, 0, 0, "R8");
    do_look(5, 1, 'h400, 1, 'hA07, "R8");

    // R5 + R9: address-scoped fence in M mode with tvm set
    do_fence(1, 'h100, 0, 0, 2'b11, 0, 5, 1, 1, 1, "R5_R9");
    do_look(5, 1, 'h100, 0, 0, "R5");
    do_look(5, 2, 'h100, 0, 0, "R5");
    do_look(9, 1, 'h100, 1, 'hB04, "R7");
    do_look(5, 1, 'h101, 1, 'hA01, "R5");

    // R6: ASID-scoped fences from S mode with vtvm set; global survives
    do_fence(0, 0, 1, 3, 2'b01, 0, 5, 0, 1, 1, "R6_R9");
    do_look(5, 3, 'h200, 1, 'hA03, "R6");
    do_fence(0, 0, 1, 1, 2'b01, 0, 5, 0, 0, 1, "R6");
    do_look(5, 1, 'h101, 0, 0, "R6");
    do_look(5, 1, 'h400, 0, 0, "R6");
    do_look(9, 1, 'h100, 1, 'hB04, "R7");
    do_look(5, 5, 'h300, 1, 'hA06, "R6");

    // R7: VMID from hgatp, not the ASID operand
    do_fence(0, 0, 1, 5, 2'b11, 0, 9, 0, 0, 1, "R7");
    do_look(9, 5, 'h300, 0, 0, "R7");
    do_look(5, 5, 'h300, 1, 'hA06, "R7");

    // R10 + R4: same-cycle lookup sees old state; full-scope fence
    @(negedge clk); clear_all();
    set_fence(0, 0, 0, 0, 2'b11, 0, 5, 0, 0, 1, "R4");
    push_look(5, 5, 'h300, 1, 'hA06, "R10");
    do_look(5, 5, 'h300, 0, 0, "R10");
    do_look(5, 9, 'h200, 0, 0, "R4");
    do_look(9, 1, 'h100, 1, 'hB04, "R4");

    // R11: fill with a same-cycle full fence lands in slot 0 and survives
    @(negedge clk); clear_all();
    set_fill(5, 1, 'h500, 'hC00, 0);
    set_fence(0, 0, 0, 0, 2'b11, 0, 5, 0, 0, 1, "R11");
    do_look(5, 1, 'h500, 1, 'hC00, "R11");

    // R11: round-robin wrap, ninth fill overwrites slot 0
    for (int i = 1; i < 8; i++) do_fill(9, 2, 'h600 + i, 'hD00 + i, 0);
    do_fill(9, 2, 'h700, 'hE00, 0);
    do_look(5, 1, 'h500, 0, 0, "R11");
    do_look(9, 2, 'h601, 1, 'hD01, "R11");
    do_look(9, 2, 'h700, 1, 'hE00, "R11");
    do_look(9, 2, 'h607, 1, 'hD07, "R11");

    @(negedge clk); clear_all();
    repeat (4) @(negedge clk);
    #6;
    foreach (q[i]) begin
      checks++;
      fail_line(q[i].req, "unchecked item", q[i].due, cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule